// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the 64-byte type-0 configuration header of a PCI endpoint. A host-side requester issues single dword-aligned 32-bit reads and writes at a 12-bit configuration offset. The block answers one cycle later with read data and an error flag.

The header provides the fixed identity words and the command register. It also holds a status half, a latency timer and header type, six base address registers arranged as three 64-bit memory pairs, the subsystem identity, a capability pointer, and the interrupt line and pin. Each implemented BAR pair is sized from a byte length given as a parameter. The length is rounded up to a power of two, and the result is never smaller than 4 KiB. Software discovers that size by writing all ones and reading back the mask.

The memory-space enable bit of the command register is driven out to the address decoders, which use it to map or unmap the BARs. While that bit is set, the BAR contents are frozen. Offsets from 0x40 to 0xFF belong to the capability structures. For those offsets the block raises a forwarding strobe toward a separate capability router and gives no response of its own. Offsets at 0x100 and above, and unaligned offsets inside the header, receive an error response.

Top module: `cfg_type0_hdr`

## Requirements
- R1: After reset, the command register, all six BARs, the interrupt line and the latency timer read zero, and `mem_decode_en` is 0.
- R2: Dword 0 reads {device id, vendor id}, dword 2 reads {24-bit class code, revision id}, and dword 11 reads {subsystem id, subsystem vendor id}, each with the identifier parameters.
- R3: Writing all ones to a BAR reads back its mask. For an implemented pair of size 2^k bytes (k at least 12), the even BAR reads ~(2^k-1) with bit 2 set and the odd BAR reads 0xFFFFFFFF. A pair with length 0 reads 0 in both BARs.
- R4: A BAR write stores the written value ANDed with the mask. An implemented even BAR always has bit 2 (64-bit type) set after any write.
- R5: BAR writes are discarded while command bit 1 is set.
- R6: A write to dword 1 keeps only command bits 1, 2 and 10. `mem_decode_en` equals command bit 1 from the cycle after that write.
- R7: Status bit 4 (dword 1 bit 20) reads 1 when capabilities exist. The capability pointer, in dword 13 bits 7:0, reads 0x40 in that case and 0 otherwise.
- R8: Dword 3 returns the latency timer in bits 15:8 and the multi-function flag in bit 23. A write changes only the latency timer.
- R9: Dword 15 holds the writable interrupt line in bits 7:0 and the fixed interrupt pin in bits 15:8.
- R10: Aligned writes below 0x40 to read-only dwords are accepted without error and change nothing.
- R11: An unaligned offset below 0x40, or any offset of 0x100 or above, gets a response with the error flag set and data 0, and no state changes.
- R12: For an offset from 0x40 to 0xFF, `cap_fwd` is high in the request cycle and no response follows.
- R13: Every request that is not forwarded gets exactly one response, in the next cycle. Writes return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_offset | input | 12 | Byte offset in configuration space |
| req_wdata | input | 32 | Write data |
| cap_fwd | output | 1 | Request belongs to the capability region |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data |
| rsp_error | output | 1 | Invalid-register response |
| mem_decode_en | output | 1 | Memory-space decode enable (command bit 1) |

## Verification
The BAR logic is exercised with all-ones sizing writes, with directed values that clear the type bit, and with random data to random BAR indices. These show apart the mask of each pair, the odd half, the unimplemented pair, and the forced type bit. A second pass repeats BAR writes with memory decoding on and then off, which isolates the write lock. Writes of all ones to every other writable dword, and to read-only dwords, show which bits each register keeps. Unaligned, extended and capability-range offsets tell the error response apart from the forwarded case.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int unsigned MIN_BAR_LOG2 = 12;

  // log2 of the decoded window: power-of-two round-up, floor of 4 KiB
  function automatic int unsigned bar_log2(input logic [31:0] len);
    int unsigned l;
    l = $clog2(len);
    if (l < MIN_BAR_LOG2) l = MIN_BAR_LOG2;
    return l;
  endfunction

  // dword slots of the header (offset[5:2])
  localparam logic [3:0] DW_ID      = 4'd0;
  localparam logic [3:0] DW_CMDSTS  = 4'd1;
  localparam logic [3:0] DW_CLASS   = 4'd2;
  localparam logic [3:0] DW_HDRLAT  = 4'd3;
  localparam logic [3:0] DW_BARBASE = 4'd4;
  localparam logic [3:0] DW_SUBSYS  = 4'd11;
  localparam logic [3:0] DW_CAPPTR  = 4'd13;
  localparam logic [3:0] DW_INTR    = 4'd15;

endpackage

// File: rtl/cfg_bar_pair.sv
module cfg_bar_pair
  import cfg_hdr_pkg::*;
#(
  parameter logic [31:0] LEN = 32'd4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [31:0] lo_q,
  output logic [31:0] hi_q
);
  localparam bit          IMPL    = (LEN != 32'd0);
  localparam int unsigned LOG2    = bar_log2(LEN);
  localparam logic [63:0] SPAN    = 64'd1 << LOG2;
  localparam logic [63:0] MASK64  = ~(SPAN - 64'd1);
  localparam logic [31:0] LO_MASK = IMPL ? (MASK64[31:0] | 32'h4) : 32'h0;
  localparam logic [31:0] HI_MASK = IMPL ? MASK64[63:32] : 32'h0;
  localparam logic [31:0] TYPE64  = IMPL ? 32'h4 : 32'h0;

  logic [31:0] lo_d, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_lo) lo_d = (wdata & LO_MASK) | TYPE64;
    if (wr_hi) hi_d = wdata & HI_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= lo_d;
      if (wr_hi) hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/cfg_hdr_rdmux.sv
module cfg_hdr_rdmux
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned NUM_BARS   = 6,
  parameter logic [15:0] VENDOR_ID  = 16'hA11C,
  parameter logic [15:0] DEVICE_ID  = 16'h5E70,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  parameter logic [15:0] SUB_VID    = 16'hA11C,
  parameter logic [15:0] SUB_ID     = 16'h0042,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter bit          MULTI_FN   = 1'b1,
  parameter bit          HAS_CAPS   = 1'b1
) (
  input  logic [3:0]               dw,
  input  logic [15:0]              cmd_q,
  input  logic [7:0]               lat_q,
  input  logic [7:0]               line_q,
  input  logic [32*NUM_BARS-1:0]   bars,
  output logic [31:0]              rdata
);
  localparam logic [15:0] STATUS = HAS_CAPS ? 16'h0010 : 16'h0000;
  localparam logic [7:0]  CAPPTR = HAS_CAPS ? 8'h40 : 8'h00;
  localparam logic [7:0]  HDRTYP = MULTI_FN ? 8'h80 : 8'h00;

  logic [3:0] bar_idx;

  always_comb begin
    bar_idx = dw - DW_BARBASE;
    rdata   = 32'h0;
    unique case (dw)
      DW_ID:     rdata = {DEVICE_ID, VENDOR_ID};
      DW_CMDSTS: rdata = {STATUS, cmd_q};
      DW_CLASS:  rdata = {CLASS_CODE, REVISION};
      DW_HDRLAT: rdata = {8'h00, HDRTYP, lat_q, 8'h00};
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9:
        if (32'(bar_idx) < NUM_BARS) rdata = bars[32*bar_idx +: 32];
      DW_SUBSYS: rdata = {SUB_ID, SUB_VID};
      DW_CAPPTR: rdata = {24'h0, CAPPTR};
      DW_INTR:   rdata = {16'h0, INT_PIN, line_q};
      default:   rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/cfg_type0_hdr.sv
module cfg_type0_hdr
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned           NUM_PAIRS  = 3,
  parameter logic [NUM_PAIRS*32-1:0] BAR_LEN  = {32'h0003_0000, 32'h0, 32'd100},
  parameter logic [15:0]           CMD_WMASK  = 16'h0406,
  parameter logic [15:0]           VENDOR_ID  = 16'hA11C,
  parameter logic [15:0]           DEVICE_ID  = 16'h5E70,
  parameter logic [7:0]            REVISION   = 8'h03,
  parameter logic [23:0]           CLASS_CODE = 24'h058000,
  parameter logic [15:0]           SUB_VID    = 16'hA11C,
  parameter logic [15:0]           SUB_ID     = 16'h0042,
  parameter logic [7:0]            INT_PIN    = 8'h01,
  parameter bit                    MULTI_FN   = 1'b1,
  parameter bit                    HAS_CAPS   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_offset,
  input  logic [31:0] req_wdata,
  output logic        cap_fwd,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_error,
  output logic        mem_decode_en
);
  localparam int unsigned NUM_BARS = 2 * NUM_PAIRS;

  logic        in_hdr, aligned, bad_off, acc_ok, wr_ok, bar_wr;
  logic [3:0]  dw;
  logic [15:0] cmd_q, cmd_d;
  logic [7:0]  lat_q, lat_d, line_q, line_d;
  logic        rsp_valid_d, rsp_error_d;
  logic [31:0] rsp_rdata_d, rd_word;
  logic [32*NUM_BARS-1:0] bars;

  // request decode
  always_comb begin
    in_hdr  = (req_offset < 12'h040);
    aligned = (req_offset[1:0] == 2'b00);
    bad_off = (in_hdr && !aligned) || (req_offset >= 12'h100);
    cap_fwd = req_valid && !in_hdr && (req_offset < 12'h100);
    acc_ok  = req_valid && in_hdr && aligned;
    wr_ok   = acc_ok && req_write;
    dw      = req_offset[5:2];
    bar_wr  = wr_ok && !cmd_q[1] && (dw >= 4'd4) && (dw <= 4'd9);
  end

  // next state
  always_comb begin
    cmd_d  = cmd_q;
    lat_d  = lat_q;
    line_d = line_q;
    if (wr_ok) begin
      unique case (dw)
        DW_CMDSTS: cmd_d  = req_wdata[15:0] & CMD_WMASK;
        DW_HDRLAT: lat_d  = req_wdata[15:8];
        DW_INTR:   line_d = req_wdata[7:0];
        default: ;
      endcase
    end
    rsp_valid_d = req_valid && !cap_fwd;
    rsp_error_d = req_valid && bad_off;
    rsp_rdata_d = (acc_ok && !req_write) ? rd_word : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      lat_q     <= '0;
      line_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_ok) begin
        cmd_q  <= cmd_d;
        lat_q  <= lat_d;
        line_q <= line_d;
      end
      rsp_valid <= rsp_valid_d;
      rsp_error <= rsp_error_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  assign mem_decode_en = cmd_q[1];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [31:0] lo_q, hi_q;
    cfg_bar_pair #(.LEN(BAR_LEN[32*p +: 32])) u_pair (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (bar_wr && (dw == 4'(4 + 2*p))),
      .wr_hi (bar_wr && (dw == 4'(5 + 2*p))),
      .wdata (req_wdata),
      .lo_q  (lo_q),
      .hi_q  (hi_q)
    );
    assign bars[64*p +: 32]      = lo_q;
    assign bars[64*p + 32 +: 32] = hi_q;
  end

  cfg_hdr_rdmux #(
    .NUM_BARS(NUM_BARS), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REVISION(REVISION), .CLASS_CODE(CLASS_CODE), .SUB_VID(SUB_VID),
    .SUB_ID(SUB_ID), .INT_PIN(INT_PIN), .MULTI_FN(MULTI_FN), .HAS_CAPS(HAS_CAPS)
  ) u_rdmux (
    .dw     (dw),
    .cmd_q  (cmd_q),
    .lat_q  (lat_q),
    .line_q (line_q),
    .bars   (bars),
    .rdata  (rd_word)
  );
endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [11:0] req_offset,
  input logic        cap_fwd,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        rsp_error,
  input logic        mem_decode_en
);
  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cap_fwd) |=> rsp_valid);

  // R13
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R12
  fwd_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fwd |=> !rsp_valid);

  // R11
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (rsp_valid && rsp_rdata == 32'h0));

  // R6
  decode_en_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_offset == 12'h004) |=> $stable(mem_decode_en));

  // R13
  write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));
endmodule

bind cfg_type0_hdr cfg_hdr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_offset(req_offset), .cap_fwd(cap_fwd), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_error(rsp_error), .mem_decode_en(mem_decode_en)
);

// File: tb/cfg_type0_hdr_test.sv
module cfg_type0_hdr_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic cap_fwd, rsp_valid, rsp_error, mem_decode_en;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0;
  logic        s_fwd, s_valid, s_err;
  logic [31:0] s_data;
  logic [31:0] model_bar [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_type0_hdr uut (.*);

  function automatic logic [31:0] bar_mask(input int i);
    case (i)
      0: return 32'hFFFFF004;
      1: return 32'hFFFFFFFF;
      4: return 32'hFFFC0004;
      5: return 32'hFFFFFFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] bar_expect(input int i, input logic [31:0] d);
    logic [31:0] v;
    v = d & bar_mask(i);
    if ((i == 0) || (i == 4)) v = v | 32'h4;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] off, input logic [31:0] d);
    req_valid  = 1'b1;
    req_write  = w;
    req_offset = off;
    req_wdata  = d;
    #1 s_fwd = cap_fwd;
    @(negedge clk);
    s_valid = rsp_valid;
    s_err   = rsp_error;
    s_data  = rsp_rdata;
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] off, input logic [31:0] exp);
    access(1'b0, off, 32'h0);
    chk(req, {s_valid, s_err}, 2'b10);
    chk(req, s_data, exp);
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    access(1'b1, off, d);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 mem_decode_en", {31'h0, mem_decode_en}, 32'h0);
    rd("R1 cmd/R7 status", 12'h004, 32'h00100000);
    for (int i = 0; i < 6; i++) rd("R1 bar", 12'(16 + 4*i), 32'h0);
    rd("R1 lat", 12'h00C, 32'h00800000);
    rd("R1 line", 12'h03C, 32'h00000100);

    // R2 identity
    rd("R2 id", 12'h000, 32'h5E70A11C);
    rd("R2 class", 12'h008, 32'h05800003);
    rd("R2 subsys", 12'h02C, 32'h0042A11C);
    // R7 cap pointer
    rd("R7 capptr", 12'h034, 32'h00000040);

    // R3 sizing
    for (int i = 0; i < 6; i++) wr(12'(16 + 4*i), 32'hFFFFFFFF);
    for (int i = 0; i < 6; i++) rd("R3 mask", 12'(16 + 4*i), bar_mask(i));

    // R4 type bit forced, AND with mask
    wr(12'h010, 32'h12345000);
    rd("R4 bar0", 12'h010, 32'h12345004);
    wr(12'h020, 32'h0);
    rd("R4 bar4 type", 12'h020, 32'h00000004);
    wr(12'h018, 32'hDEADBEEF);
    rd("R4 unimpl", 12'h018, 32'h0);

    // R4 random
    for (int n = 0; n < 40; n++) begin
      int i;
      logic [31:0] d;
      i = int'($urandom % 6);
      d = $urandom;
      wr(12'(16 + 4*i), d);
      rd("R4 random", 12'(16 + 4*i), bar_expect(i, d));
    end

    // R6 command mask and decode enable
    wr(12'h010, 32'h0);
    wr(12'h004, 32'hFFFFFFFF);
    chk("R6 mem_decode_en on", {31'h0, mem_decode_en}, 32'h1);
    rd("R6 cmd", 12'h004, 32'h00100406);

    // R5 lock while enabled
    wr(12'h010, 32'hABCDE000);
    rd("R5 locked", 12'h010, 32'h00000004);
    wr(12'h004, 32'h0);
    chk("R6 mem_decode_en off", {31'h0, mem_decode_en}, 32'h0);
    wr(12'h010, 32'hABCDE000);
    rd("R5 unlocked", 12'h010, 32'hABCDE004);

    // R8 latency timer
    wr(12'h00C, 32'hFFFFFFFF);
    rd("R8 lat", 12'h00C, 32'h0080FF00);

    // R9 interrupt line
    wr(12'h03C, 32'hFFFFFFFF);
    rd("R9 line", 12'h03C, 32'h000001FF);

    // R10 read-only writes
    wr(12'h000, 32'h0);
    chk("R10 no err", {s_valid, s_err}, 2'b10);
    wr(12'h034, 32'h0);
    chk("R10 no err capptr", {s_valid, s_err}, 2'b10);
    rd("R10 id", 12'h000, 32'h5E70A11C);
    rd("R10 capptr", 12'h034, 32'h00000040);

    // R11 errors
    wr(12'h005, 32'h00000002);
    chk("R11 unaligned", {s_valid, s_err}, 2'b11);
    chk("R11 unaligned data", s_data, 32'h0);
    chk("R11 no state", {31'h0, mem_decode_en}, 32'h0);
    rd("R11 cmd unchanged", 12'h004, 32'h00100000);
    access(1'b0, 12'h00E, 32'h0);
    chk("R11 unaligned rd", {s_valid, s_err, s_data}, {2'b11, 32'h0});
    access(1'b0, 12'h100, 32'h0);
    chk("R11 ext rd", {s_valid, s_err, s_data}, {2'b11, 32'h0});
    access(1'b1, 12'h7FC, 32'hFFFFFFFF);
    chk("R11 ext wr", {s_valid, s_err}, 2'b11);

    // R12 capability forwarding
    access(1'b0, 12'h040, 32'h0);
    chk("R12 fwd 0x40", {s_fwd, s_valid}, 2'b10);
    access(1'b1, 12'h0FC, 32'h1);
    chk("R12 fwd 0xFC", {s_fwd, s_valid}, 2'b10);
    access(1'b0, 12'h03C, 32'h0);
    chk("R12 R13 no fwd 0x3C", {s_fwd, s_valid}, 2'b01);

    // R13 idle: no response without request
    @(negedge clk);
    chk("R13 idle", {31'h0, rsp_valid}, 32'h0);

    // R1 reset again after state was set
    wr(12'h004, 32'h2);
    do_reset();
    chk("R1 re-reset decode", {31'h0, mem_decode_en}, 32'h0);
    rd("R1 re-reset bar4", 12'h020, 32'h0);
    rd("R1 re-reset lat", 12'h00C, 32'h00800000);
    rd("R1 re-reset line", 12'h03C, 32'h00000100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule